// File: doc/BRIEF.md
# CCMP Additional Authentication Data Formatter

This block turns the fields of a wireless MAC header into the two 128-bit authentication blocks that precede the payload in a CCM CBC-MAC chain. The fields arrive one 16-bit word at a time. A 16-bit bus keeps logic small and still fills one 128-bit block well within the ten-cycle period of an iterative cipher core. Each word is qualified by `in_valid`. A `start` strobe opens a frame and samples two presence flags. One flag says whether a fourth address follows the sequence-control word. The other says whether a QoS-control word follows.

The formatter puts a big-endian octet count in front of the header words. It masks the frame-control and sequence-control words, passes the address words and the optional fields through unchanged, and fills the rest with zeros up to exactly 256 bits. It issues the result as two 128-bit blocks, each flagged for one cycle. An index bit tells which block is on the bus, and a last flag marks the second block. Each 16-bit output word is taken from one of five sources: the length value, masked frame control, masked sequence control, a raw input word, or zero.

Top module: `ccmp_aad_fmt`

## Requirements
- R1: The first 16-bit word of block 0 (bits 127:112) is the AAD octet count: 22 with no optional field, 24 with QoS control only, 28 with the fourth address only, and 30 with both.
- R2: After the count word the input words appear in arrival order: frame control, three words each of addresses 1, 2 and 3, sequence control, then three fourth-address words when that flag is set, then one QoS word when that flag is set. Output word k of the 256-bit pair occupies bits 127-16k down to 112-16k of block 0 for k<8, and the same positions of block 1 for k-8.
- R3: The frame-control word (first input word) is output with bits 15:12 and 5:3 cleared, bit 6 set, and every other bit unchanged.
- R4: The sequence-control word (eleventh input word) is output with bits 11:8 kept and all other bits zero.
- R5: Every output word after the last header word, up to word 15, is zero.
- R6: The presence flags are sampled only on a `start` accepted while idle. A `start` pulse or flag change during a frame has no effect on that frame.
- R7: An input word is taken only on a clock edge where `in_valid` is high. Cycles without it stall assembly and leave the result unchanged.
- R8: `in_valid` words presented while idle or during the padding phase are discarded and produce no block.
- R9: Each frame yields exactly two single-cycle `blk_valid` pulses. Block 0 has `blk_idx`=0 and `blk_last`=0 and comes first. Block 1 has `blk_idx`=1 and `blk_last`=1.
- R10: After reset, `blk_valid` is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a frame when idle |
| flag_a4 | input | 1 | Fourth address present (sampled with start) |
| flag_qc | input | 1 | QoS control present (sampled with start) |
| in_valid | input | 1 | Qualifies in_word |
| in_word | input | 16 | Header word, first octet in bits 15:8 |
| blk_valid | output | 1 | One-cycle strobe for a finished block |
| blk_data | output | 128 | Assembled block, first word in bits 127:112 |
| blk_idx | output | 1 | 0 for the first block, 1 for the second |
| blk_last | output | 1 | High with the second block |

## Verification
The assertions assume that `start` is raised only between frames and that a frame receives exactly as many valid words as its latched flags call for. A frame given too few words would stall forever, and this block does not check for it. The stimulus follows the same rule. It pulses `start` once from idle, waits for both blocks before the next frame, and sends exactly the required word count. Any extra `in_valid` activity falls only where the requirements say it is ignored: while idle, in the padding phase, or as a mid-frame `start` with inverted flags.

// File: rtl/ccmp_aad_pkg.sv
package ccmp_aad_pkg;
  localparam int WORD_W     = 16;
  localparam int BLK_W      = 128;
  localparam int NUM_BLKS   = 2;
  localparam int WPB        = BLK_W / WORD_W;
  localparam int SLOTS      = WPB * NUM_BLKS;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int LANE_W     = $clog2(WPB);
  localparam int BASE_WORDS = 11;
  localparam int A4_WORDS   = 3;
  localparam int QC_WORDS   = 1;
  localparam int FC_POS     = 0;
  localparam int SC_POS     = 10;
  localparam int CNT_W      = SLOT_W + 1;

  typedef enum logic [2:0] {
    SRC_LEN,
    SRC_FC,
    SRC_SC,
    SRC_RAW,
    SRC_ZERO
  } src_e;

  // header words expected for a given pair of presence flags
  function automatic logic [CNT_W-1:0] aad_words(input logic a4, input logic qc);
    int n;
    n = BASE_WORDS + (a4 ? A4_WORDS : 0) + (qc ? QC_WORDS : 0);
    return CNT_W'(n);
  endfunction

  function automatic logic [WORD_W-1:0] aad_octets(input logic a4, input logic qc);
    return WORD_W'(2 * int'(aad_words(a4, qc)));
  endfunction

  // frame control: drop subtype, retry, power management, more data; force protected
  function automatic logic [WORD_W-1:0] mask_fc(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r        = w;
    r[15:12] = 4'h0;
    r[5:3]   = 3'b000;
    r[6]     = 1'b1;
    return r;
  endfunction

  // sequence control: keep fragment number only
  function automatic logic [WORD_W-1:0] mask_sc(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r        = '0;
    r[11:8]  = w[11:8];
    return r;
  endfunction
endpackage

// File: rtl/aad_seq.sv
module aad_seq
  import ccmp_aad_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                flag_a4,
  input  logic                flag_qc,
  input  logic                in_valid,
  output logic                busy,
  output logic [SLOT_W-1:0]   slot,
  output src_e                src,
  output logic                push,
  output logic                take,
  output logic                pad_phase,
  output logic [WORD_W-1:0]   len_val
);
  logic             a4_q, qc_q;
  logic             launch;
  logic             frame_done;
  logic [CNT_W-1:0] n_in;
  logic [SLOT_W-1:0] didx;

  assign launch = start && !busy;
  assign n_in   = aad_words(a4_q, qc_q);
  assign didx   = slot - SLOT_W'(1);
  assign len_val = aad_octets(flag_a4, flag_qc);

  always_comb begin
    push      = 1'b0;
    take      = 1'b0;
    pad_phase = 1'b0;
    src       = SRC_ZERO;
    if (launch) begin
      push = 1'b1;
      src  = SRC_LEN;
    end else if (busy) begin
      if ({1'b0, slot} <= n_in) begin
        push = in_valid;
        take = in_valid;
        if (didx == SLOT_W'(FC_POS))      src = SRC_FC;
        else if (didx == SLOT_W'(SC_POS)) src = SRC_SC;
        else                              src = SRC_RAW;
      end else begin
        push      = 1'b1;
        pad_phase = 1'b1;
        src       = SRC_ZERO;
      end
    end
  end

  assign frame_done = busy && push && (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
      a4_q <= 1'b0;
      qc_q <= 1'b0;
    end else if (launch) begin
      busy <= 1'b1;
      slot <= SLOT_W'(1);
      a4_q <= flag_a4;
      qc_q <= flag_qc;
    end else if (busy && push) begin
      slot <= slot + SLOT_W'(1);
      if (frame_done) busy <= 1'b0;
    end
  end

  // R8: nothing is consumed while idle
  a_r8_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !take);

  // R6: latched flags hold for the whole frame
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> (busy && $stable(a4_q) && $stable(qc_q)));

  // R7: a data slot without valid leaves the slot counter in place
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pad_phase && !in_valid) |=> $stable(slot));
endmodule

// File: rtl/aad_wordsel.sv
module aad_wordsel
  import ccmp_aad_pkg::*;
(
  input  src_e              src,
  input  logic [WORD_W-1:0] in_word,
  input  logic [WORD_W-1:0] len_val,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    unique case (src)
      SRC_LEN: word = len_val;
      SRC_FC:  word = mask_fc(in_word);
      SRC_SC:  word = mask_sc(in_word);
      SRC_RAW: word = in_word;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/aad_packer.sv
module aad_packer
  import ccmp_aad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SLOT_W-1:0] slot,
  input  logic [WORD_W-1:0] word,
  output logic              blk_valid,
  output logic [BLK_W-1:0]  blk_data,
  output logic              blk_idx,
  output logic              blk_last
);
  logic [LANE_W-1:0] lane;
  logic              blk_full;
  logic [BLK_W-1:0]  lane_bus;

  assign lane     = slot[LANE_W-1:0];
  assign blk_full = push && (lane == LANE_W'(WPB - 1));

  genvar g;
  generate
    for (g = 0; g < WPB - 1; g++) begin : g_lane
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= '0;
        else if (push && lane == LANE_W'(g)) q <= word;
      end
      assign lane_bus[(WPB-1-g)*WORD_W +: WORD_W] = q;
    end
  endgenerate
  assign lane_bus[WORD_W-1:0] = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_valid <= 1'b0;
      blk_data  <= '0;
      blk_idx   <= 1'b0;
      blk_last  <= 1'b0;
    end else begin
      blk_valid <= blk_full;
      if (blk_full) begin
        blk_data <= lane_bus;
        blk_idx  <= slot[SLOT_W-1];
        blk_last <= (slot[SLOT_W-1:LANE_W] == (SLOT_W-LANE_W)'(NUM_BLKS - 1));
      end
    end
  end

  // R9: strobe is one cycle wide
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> !blk_valid);

  // R9: last flag accompanies the second block only
  a_r9_last_is_second: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (blk_last == blk_idx));
endmodule

// File: rtl/ccmp_aad_fmt.sv
module ccmp_aad_fmt
  import ccmp_aad_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         flag_a4,
  input  logic         flag_qc,
  input  logic         in_valid,
  input  logic [15:0]  in_word,
  output logic         blk_valid,
  output logic [127:0] blk_data,
  output logic         blk_idx,
  output logic         blk_last
);
  logic              busy;
  logic [SLOT_W-1:0] slot;
  src_e              src;
  logic              push;
  logic              take;
  logic              pad_phase;
  logic [WORD_W-1:0] len_val;
  logic [WORD_W-1:0] word;

  aad_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .flag_a4(flag_a4),
    .flag_qc(flag_qc), .in_valid(in_valid), .busy(busy), .slot(slot),
    .src(src), .push(push), .take(take), .pad_phase(pad_phase),
    .len_val(len_val)
  );

  aad_wordsel u_sel (
    .src(src), .in_word(in_word), .len_val(len_val), .word(word)
  );

  aad_packer u_pack (
    .clk(clk), .rst_n(rst_n), .push(push), .slot(slot), .word(word),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_idx(blk_idx),
    .blk_last(blk_last)
  );

  // R5: padding slots feed zero words into the packer
  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pad_phase |-> (push && word == '0));

  // R1: block 0 always opens with one of the four legal octet counts
  a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_idx) |-> (blk_data[127:112] inside {16'd22, 16'd24, 16'd28, 16'd30}));

  // R3: frame control in block 0 carries the protected bit and a cleared subtype
  a_r3_fc_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && !blk_idx) |-> (blk_data[102] && blk_data[111:108] == 4'h0));

  // R8: no word is taken while the frame is padding
  a_r8_pad_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    pad_phase |-> !take);
endmodule

// File: tb/ccmp_aad_fmt_tb_top.sv
`timescale 1ns/1ps
module ccmp_aad_fmt_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         flag_a4 = 1'b0;
  logic         flag_qc = 1'b0;
  logic         in_valid = 1'b0;
  logic [15:0]  in_word = '0;
  logic         blk_valid;
  logic [127:0] blk_data;
  logic         blk_idx;
  logic         blk_last;

  always #2 clk = ~clk;

  ccmp_aad_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .flag_a4(flag_a4),
    .flag_qc(flag_qc), .in_valid(in_valid), .in_word(in_word),
    .blk_valid(blk_valid), .blk_data(blk_data), .blk_idx(blk_idx),
    .blk_last(blk_last)
  );

  int tests = 0;
  int fails = 0;
  string cur_tag = "R2";
  logic [128:0] expq[$];
  logic [127:0] cap0, cap1;
  int blk_seen = 0;
  bit prev_valid = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a block appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (blk_valid && prev_valid) check(1'b0, "R9 double strobe", 128'd1, 128'd0);
      if (blk_valid) begin
        blk_seen++;
        if (expq.size() == 0) begin
          check(1'b0, "R8 unexpected block", blk_data, 128'd0);
        end else begin
          logic [128:0] e;
          e = expq.pop_front();
          check(blk_idx == e[128], "R9 index", 128'(blk_idx), 128'(e[128]));
          check(blk_last == e[128], "R9 last", 128'(blk_last), 128'(e[128]));
          check(blk_data == e[127:0], cur_tag, blk_data, e[127:0]);
          if (blk_idx) cap1 = blk_data; else cap0 = blk_data;
        end
      end
    end
    prev_valid = blk_valid;
  end

  function automatic logic [15:0] fc_ref(input logic [15:0] w);
    return (w & 16'h0FC7) | 16'h0040;
  endfunction

  function automatic logic [15:0] sc_ref(input logic [15:0] w);
    return w & 16'h0F00;
  endfunction

  task automatic run_frame(input bit a4, input bit qc, input int gap,
                           input bit disturb, input int seed, input string tag);
    logic [15:0] w[15];
    logic [255:0] pair;
    int n;
    int seen0;
    logic [15:0] len;
    n = 11 + (a4 ? 3 : 0) + (qc ? 1 : 0);
    len = 16'(2 * n);
    for (int i = 0; i < 15; i++) w[i] = 16'((seed * 16'h3B1D) ^ (i * 16'h9E37) ^ 16'hFFFF);
    pair = '0;
    pair[255 -: 16] = len;
    for (int i = 0; i < n; i++) begin
      logic [15:0] v;
      v = (i == 0) ? fc_ref(w[i]) : (i == 10) ? sc_ref(w[i]) : w[i];
      pair[255 - 16*(i+1) -: 16] = v;
    end
    expq.push_back({1'b0, pair[255:128]});
    expq.push_back({1'b1, pair[127:0]});
    cur_tag = tag;
    seen0 = blk_seen;
    @(negedge clk);
    start = 1'b1; flag_a4 = a4; flag_qc = qc;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < gap; k++) begin
        in_valid = 1'b0; in_word = 16'hDEAD;
        @(negedge clk);
      end
      in_valid = 1'b1; in_word = w[i];
      if (disturb && i == 3) begin
        start = 1'b1; flag_a4 = ~a4; flag_qc = ~qc;
      end
      @(negedge clk);
      start = 1'b0; flag_a4 = a4; flag_qc = qc;
    end
    // noise during padding / after the frame (R8)
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1; in_word = 16'hBEEF;
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (14) @(negedge clk);
    check(blk_seen - seen0 == 2, "R9 block count", 128'(blk_seen - seen0), 128'd2);
    check(cap0[127:112] == len, "R1 length word", 128'(cap0[127:112]), 128'(len));
    check(cap0[111:96] == fc_ref(w[0]), "R3 frame control",
          128'(cap0[111:96]), 128'(fc_ref(w[0])));
    check(cap1[79:64] == sc_ref(w[10]), "R4 sequence control",
          128'(cap1[79:64]), 128'(sc_ref(w[10])));
    for (int k = n + 1; k < 16; k++) begin
      logic [15:0] pw;
      pw = (k < 8) ? cap0[127 - 16*k -: 16] : cap1[127 - 16*(k-8) -: 16];
      check(pw == 16'h0, "R5 padding", 128'(pw), 128'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(blk_valid == 1'b0, "R10 reset valid", 128'(blk_valid), 128'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(blk_valid == 1'b0, "R10 idle after reset", 128'(blk_valid), 128'd0);
    // R8: noise while idle produces nothing
    for (int k = 0; k < 5; k++) begin
      in_valid = 1'b1; in_word = 16'(k * 16'h1357);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(blk_seen == 0, "R8 idle words ignored", 128'(blk_seen), 128'd0);
    // R2: all four flag combinations
    run_frame(1'b0, 1'b0, 0, 1'b0, 1, "R2 no options");
    run_frame(1'b0, 1'b1, 0, 1'b0, 2, "R2 qos only");
    run_frame(1'b1, 1'b0, 0, 1'b0, 3, "R2 a4 only");
    run_frame(1'b1, 1'b1, 0, 1'b0, 4, "R2 both");
    // R7: gaps between valid words
    run_frame(1'b1, 1'b0, 2, 1'b0, 5, "R7 gaps");
    run_frame(1'b0, 1'b1, 1, 1'b0, 6, "R7 single gaps");
    // R6: mid-frame start with inverted flags
    run_frame(1'b0, 1'b0, 0, 1'b1, 7, "R6 start while busy");
    run_frame(1'b1, 1'b1, 1, 1'b1, 8, "R6 start while busy both");
    check(expq.size() == 0, "R9 scoreboard drained", 128'(expq.size()), 128'd0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule